// File: doc/BRIEF.md
# Multicycle Datapath Sequencer

This block is the control sequencer for a multicycle processor datapath that executes one instruction over several clock cycles. It is a Moore state machine. Every control output depends only on the current state, and the instruction opcode only decides which state comes next. Two states are shared by all instructions: a fetch state and a decode/register-read state. After those, each instruction class follows its own short path of one to three states and then goes back to fetch. The classes are load word, store word, register-register arithmetic, OR with an immediate, and branch-if-equal.

The surrounding datapath holds the instruction register, the register file, the memory, the ALU and the program counter. It feeds the opcode field of the latched instruction back to this block. The opcode must stay stable from the decode state until the instruction's last state. Any control that has no meaning in a state is driven low.

Top module: `mcfsm_ctrl`

## Requirements
- R1: While reset is asserted (reset is asynchronous and active-low), and through the two synchronizer cycles after it is released, the outputs show the fetch pattern: `pc_wr`=1 and `ir_wr`=1, with every other output 0 and `alu_op`=00 (add).
- R2: The fetch state is always followed by the decode state. Decode drives `br_wr`=1, `ext_op`=1, `alu_sel_b`=10 and `alu_op`=00, with every other output 0.
- R3: The opcode encodings are 6'h23 load, 6'h2B store, 6'h00 register type, 6'h0D OR-immediate and 6'h04 branch. From decode, any other opcode goes straight back to fetch.
- R4: A branch runs one state after decode. That state drives `pc_wr_cond`=1, `pc_src`=1, `alu_sel_a`=1, `alu_sel_b`=00 and `alu_op`=01 (subtract).
- R5: A load or store goes from decode to an address state. The address state drives `ext_op`=1, `alu_sel_a`=1, `alu_sel_b`=11 and `alu_op`=00. The same four values are held in every later state of both paths.
- R6: After the address state, a store goes to a memory-write state. This state adds `mem_wr`=1 to the address-state pattern.
- R7: After the address state, a load goes to a memory-read state, which adds `i_or_d`=1. It then goes to a write-back state, which also adds `reg_wr`=1 and `mem_to_reg`=1.
- R8: A register-type instruction runs an execute state followed by a finish state. Both drive `alu_sel_a`=1, `reg_dst`=1, `alu_sel_b`=00 and `alu_op`=10. The finish state adds `reg_wr`=1.
- R9: An OR-immediate runs an execute state followed by a finish state. Both drive `alu_sel_a`=1, `alu_sel_b`=11, `alu_op`=11 and `reg_dst`=0. The finish state adds `reg_wr`=1.
- R10: The last state of every path is followed by fetch. Counting fetch, the totals are 5 cycles for load, 4 for store, register type and OR-immediate, 3 for branch, and 2 for an unknown opcode.
- R11: `mem_wr` and `reg_wr` are never high together, and neither is ever high at the same time as `ir_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| opcode | input | 6 | Opcode field of the latched instruction |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by the ALU zero flag |
| ir_wr | output | 1 | Instruction register write |
| br_wr | output | 1 | Branch target register write |
| reg_wr | output | 1 | Register file write |
| mem_wr | output | 1 | Memory write |
| reg_dst | output | 1 | Destination register select (1 = rd field) |
| mem_to_reg | output | 1 | Register write data from memory |
| i_or_d | output | 1 | Memory address from the ALU result instead of the PC |
| pc_src | output | 1 | PC source is the branch target register |
| ext_op | output | 1 | Sign-extend the immediate |
| alu_sel_a | output | 1 | ALU operand A from the register file instead of the PC |
| alu_sel_b | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU function: 00 add, 01 subtract, 10 function field, 11 OR |

## Verification
If the state register ends up in a wrong state, the control word on the ports is wrong in the very next cycle, because each state has a pattern that no other state shares. A wrong dispatch is therefore visible one cycle after decode. A missing return to fetch shows up as a late or absent `ir_wr` pulse at the cycle where that instruction's fixed length says fetch is due. The bench sweeps all 64 opcode values and compares the whole control word in every cycle. This covers every transition, the fallback for unknown opcodes, and an asynchronous reset applied partway through a path.

// File: rtl/mcfsm_pkg.sv
package mcfsm_pkg;

  localparam int OP_W = 6;
  localparam int ST_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORIMM = 6'h0D;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDMEM  = 4'd3,
    S_LDWB   = 4'd4,
    S_STMEM  = 4'd5,
    S_REXE   = 4'd6,
    S_RFIN   = 4'd7,
    S_BRANCH = 4'd8,
    S_SPARE  = 4'd9,
    S_OREXE  = 4'd10,
    S_ORFIN  = 4'd11
  } state_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_FN  = 2'b10,
    ALU_OR  = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       br_wr;
    logic       reg_wr;
    logic       mem_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       i_or_d;
    logic       pc_src;
    logic       ext_op;
    logic       alu_sel_a;
    logic [1:0] alu_sel_b;
    alu_fn_e    alu_op;
  } ctrl_t;

endpackage

// File: rtl/mcfsm_rst_sync.sv
module mcfsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcfsm_next.sv
module mcfsm_next
  import mcfsm_pkg::*;
(
  input  state_e          cur_state,
  input  logic [OP_W-1:0] opcode,
  output state_e          nxt_state
);
  always_comb begin
    nxt_state = S_FETCH;
    unique case (cur_state)
      S_FETCH:  nxt_state = S_DECODE;
      S_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt_state = S_ADDR;
        else if (opcode == OPC_RTYPE)                  nxt_state = S_REXE;
        else if (opcode == OPC_ORIMM)                  nxt_state = S_OREXE;
        else if (opcode == OPC_BRANCH)                 nxt_state = S_BRANCH;
        else                                           nxt_state = S_FETCH;
      end
      S_ADDR:   nxt_state = (opcode == OPC_STORE) ? S_STMEM : S_LDMEM;
      S_LDMEM:  nxt_state = S_LDWB;
      S_REXE:   nxt_state = S_RFIN;
      S_OREXE:  nxt_state = S_ORFIN;
      default:  nxt_state = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcfsm_decode.sv
module mcfsm_decode
  import mcfsm_pkg::*;
(
  input  state_e cur_state,
  output ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (cur_state)
      S_FETCH: begin
        ctrl.pc_wr = 1'b1;
        ctrl.ir_wr = 1'b1;
      end
      S_DECODE: begin
        ctrl.br_wr     = 1'b1;
        ctrl.ext_op    = 1'b1;
        ctrl.alu_sel_b = 2'b10;
      end
      S_BRANCH: begin
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = 1'b1;
        ctrl.alu_sel_a  = 1'b1;
        ctrl.alu_op     = ALU_SUB;
      end
      S_ADDR, S_LDMEM, S_LDWB, S_STMEM: begin
        ctrl.ext_op     = 1'b1;
        ctrl.alu_sel_a  = 1'b1;
        ctrl.alu_sel_b  = 2'b11;
        ctrl.mem_wr     = (cur_state == S_STMEM);
        ctrl.i_or_d     = (cur_state == S_LDMEM) || (cur_state == S_LDWB);
        ctrl.reg_wr     = (cur_state == S_LDWB);
        ctrl.mem_to_reg = (cur_state == S_LDWB);
      end
      S_REXE, S_RFIN: begin
        ctrl.alu_sel_a = 1'b1;
        ctrl.reg_dst   = 1'b1;
        ctrl.alu_op    = ALU_FN;
        ctrl.reg_wr    = (cur_state == S_RFIN);
      end
      S_OREXE, S_ORFIN: begin
        ctrl.alu_sel_a = 1'b1;
        ctrl.alu_sel_b = 2'b11;
        ctrl.alu_op    = ALU_OR;
        ctrl.reg_wr    = (cur_state == S_ORFIN);
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcfsm_ctrl.sv
module mcfsm_ctrl
  import mcfsm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            ir_wr,
  output logic            br_wr,
  output logic            reg_wr,
  output logic            mem_wr,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            i_or_d,
  output logic            pc_src,
  output logic            ext_op,
  output logic            alu_sel_a,
  output logic [1:0]      alu_sel_b,
  output logic [1:0]      alu_op
);
  logic   rst_q_n;
  state_e state_q, state_d;
  ctrl_t  ctrl;

  mcfsm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  mcfsm_next u_next (
    .cur_state (state_q),
    .opcode    (opcode),
    .nxt_state (state_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= S_FETCH;
    else          state_q <= state_d;
  end

  mcfsm_decode u_dec (
    .cur_state (state_q),
    .ctrl      (ctrl)
  );

  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign ir_wr      = ctrl.ir_wr;
  assign br_wr      = ctrl.br_wr;
  assign reg_wr     = ctrl.reg_wr;
  assign mem_wr     = ctrl.mem_wr;
  assign reg_dst    = ctrl.reg_dst;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign i_or_d     = ctrl.i_or_d;
  assign pc_src     = ctrl.pc_src;
  assign ext_op     = ctrl.ext_op;
  assign alu_sel_a  = ctrl.alu_sel_a;
  assign alu_sel_b  = ctrl.alu_sel_b;
  assign alu_op     = ctrl.alu_op;

  logic known_op;
  assign known_op = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                    (opcode == OPC_RTYPE) || (opcode == OPC_ORIMM) ||
                    (opcode == OPC_BRANCH);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_q_n)
    ir_wr |=> br_wr);
  a_r3_unknown_refetch: assert property (@(posedge clk) disable iff (!rst_q_n)
    (br_wr && !known_op) |=> ir_wr);
  a_r4_branch_returns: assert property (@(posedge clk) disable iff (!rst_q_n)
    pc_wr_cond |=> ir_wr);
  a_r7_load_read_then_wb: assert property (@(posedge clk) disable iff (!rst_q_n)
    (i_or_d && !reg_wr) |=> (reg_wr && mem_to_reg));
  a_r10_store_returns: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_wr |=> ir_wr);
  a_r10_regwr_returns: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_wr |=> ir_wr);
  a_r11_write_excl: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({mem_wr, reg_wr, ir_wr}));
endmodule

// File: tb/mcfsm_ctrl_tb.sv
module mcfsm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic pc_wr, pc_wr_cond, ir_wr, br_wr, reg_wr, mem_wr, reg_dst;
  logic mem_to_reg, i_or_d, pc_src, ext_op, alu_sel_a;
  logic [1:0] alu_sel_b, alu_op;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcfsm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .br_wr(br_wr),
    .reg_wr(reg_wr), .mem_wr(mem_wr), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .i_or_d(i_or_d), .pc_src(pc_src),
    .ext_op(ext_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .alu_op(alu_op)
  );

  // Control word layout: bit15 pc_wr .. bit4 alu_sel_a, [3:2] sel_b, [1:0] alu_op
  localparam logic [15:0] W_FETCH = 16'hA000;
  localparam logic [15:0] W_DEC   = 16'h1028;
  localparam logic [15:0] W_BR    = 16'h4051;
  localparam logic [15:0] W_ADDR  = 16'h003C;
  localparam logic [15:0] W_STM   = 16'h043C;
  localparam logic [15:0] W_LDM   = 16'h00BC;
  localparam logic [15:0] W_LDWB  = 16'h09BC;
  localparam logic [15:0] W_REX   = 16'h0212;
  localparam logic [15:0] W_RFIN  = 16'h0A12;
  localparam logic [15:0] W_OREX  = 16'h001F;
  localparam logic [15:0] W_ORFIN = 16'h081F;

  function automatic logic [15:0] word_now();
    return {pc_wr, pc_wr_cond, ir_wr, br_wr, reg_wr, mem_wr, reg_dst,
            mem_to_reg, i_or_d, pc_src, ext_op, alu_sel_a, alu_sel_b, alu_op};
  endfunction

  // class: 0 unknown, 1 load, 2 store, 3 reg type, 4 or-imm, 5 branch (R3)
  function automatic int op_class(input logic [5:0] op);
    case (op)
      6'h23:   return 1;
      6'h2B:   return 2;
      6'h00:   return 3;
      6'h0D:   return 4;
      6'h04:   return 5;
      default: return 0;
    endcase
  endfunction

  // path length including fetch (R10)
  function automatic int path_len(input int c);
    case (c)
      1:       return 5;
      2, 3, 4: return 4;
      5:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input int c, input int step);
    if (step == 0) return W_FETCH;
    if (step == 1) return W_DEC;
    case (c)
      1: return (step == 2) ? W_ADDR : (step == 3) ? W_LDM : W_LDWB;
      2: return (step == 2) ? W_ADDR : W_STM;
      3: return (step == 2) ? W_REX : W_RFIN;
      4: return (step == 2) ? W_OREX : W_ORFIN;
      5: return W_BR;
      default: return W_FETCH;
    endcase
  endfunction

  function automatic string req_of(input int c, input int step);
    if (step == 0) return "R10";
    if (step == 1) return "R2";
    case (c)
      1: return (step == 2) ? "R5" : "R7";
      2: return (step == 2) ? "R5" : "R6";
      3: return "R8";
      4: return "R9";
      5: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    logic [15:0] act;
    act = word_now();
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: control word %h expected %h (opcode %h)", req, act, exp, opcode);
    end
    // R11: write strobes exclusive
    n_checks++;
    if ((mem_wr + reg_wr + ir_wr) > 1) begin
      n_fail++;
      $display("FAIL R11: mem_wr/reg_wr/ir_wr = %b%b%b expected at most one", mem_wr, reg_wr, ir_wr);
    end
  endtask

  task automatic run_op(input logic [5:0] op);
    int c;
    opcode = op;
    c = op_class(op);
    for (int s = 0; s < path_len(c); s++) begin
      check(req_of(c, s), exp_word(c, s));
      @(posedge clk);
      #(CLK_PERIOD/2);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 6'h00;
    #1;
    check("R1", W_FETCH);            // during reset
    #(CLK_PERIOD*3);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", W_FETCH);
    @(posedge clk); #(CLK_PERIOD/2);
    check("R1", W_FETCH);
    @(posedge clk); #(CLK_PERIOD/2);
    // now in fetch, next edge moves on
    for (int op = 0; op < 64; op++) run_op(6'(op));
    // repeat the known classes back to back
    run_op(6'h04); run_op(6'h23); run_op(6'h2B); run_op(6'h0D); run_op(6'h00);
    // R1: asynchronous reset partway through a load
    opcode = 6'h23;
    for (int s = 0; s < 2; s++) begin @(posedge clk); #(CLK_PERIOD/2); end
    check("R5", W_ADDR);
    #1 rst_n = 1'b0;
    #1 check("R1", W_FETCH);
    @(posedge clk); #(CLK_PERIOD/2);
    check("R1", W_FETCH);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/2);
    check("R1", W_FETCH);
    @(posedge clk); #(CLK_PERIOD/2);
    run_op(6'h23);
    run_op(6'h3F);
    finish_up();
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end
endmodule